// File: doc/BRIEF.md
# Bit-Serial CRC Generator for a Memory-Card Link

This block computes a cyclic redundancy check one bit per clock, using a generator polynomial that is fixed when the block is built. The same port list serves both a 7-bit remainder for command frames and a 16-bit remainder for data blocks. The data bits arrive in the order they go onto the wire. A qualifier marks which cycles carry message bits, and a strobe acts as a clock enable.

While the qualifier is high, the register absorbs one message bit on each enabled edge. After the qualifier drops, the finished remainder is available in parallel. On the following enabled cycles the same register shifts that remainder out on a serial pin, most significant bit first, and after one bit per remainder position it is empty again. A synchronous clear empties the register at any time.

Top module: `sd_serial_crc`

## Requirements
- R1: The synchronous reset makes the remainder register all zeros, so the parallel output is zero and the serial output is low on the cycle after reset.
- R2: On each rising edge where the strobe and the qualifier are high, the register absorbs one message bit, first-sent bit first. The polynomial is a parameter given without its top term: 0x09 for x^7+x^3+1 and 0x1021 for x^16+x^12+x^5+1. The start value is zero and there is no final inversion.
- R3: In the 7-bit variant, the parallel output holds these remainders once the qualifier drops: 0x4A for 0x40 followed by 32 zero bits, 0x2A for 0x51 followed by 32 zero bits, and 0x33 for the 40 bits 0x1100000900.
- R4: In the 16-bit variant, the remainders are 0x2FBC for the bytes 0x1234567890ABCDEF, 0x63E2 for ten bytes of 0xF0, and 0x7FA1 for 512 bytes of 0xFF.
- R5: A message followed by its own remainder bits, most significant bit first, leaves a remainder of zero.
- R6: With the qualifier low and the strobe high, the serial output presents the remainder most significant bit first, one bit per cycle. After as many cycles as the register has bits, the parallel output is zero.
- R7: The serial output is low whenever the qualifier is high.
- R8: When the strobe is low and clear is low, the register keeps its value in both absorb and shift-out modes, whatever the data input is.
- R9: Clear is synchronous and empties the register on the next edge. It takes priority over the qualifier and the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High: absorb din; low: shift the remainder out |
| step_en | input | 1 | Clock enable for the register |
| clr | input | 1 | Synchronous clear, active high |
| din | input | 1 | Message bit |
| crc_par | output | WIDTH | Current remainder |
| crc_ser | output | 1 | Serial remainder bit, MSB first |

## Verification
Clear can arrive in the same cycle as an absorb or shift-out step, and it can also arrive in a cycle where the strobe is low. The bench raises clear in the middle of a message with the qualifier high and the strobe both low and high, and again in the middle of a shift-out. It then checks that the parallel and serial outputs are zero on the next cycle. It also checks that a fresh message sent afterwards gives its stated remainder, which shows that nothing from the interrupted message remained in the register.

// File: rtl/sd_serial_crc.sv
module sd_serial_crc #(
  parameter int WIDTH = 7,
  parameter logic [WIDTH-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst_sync,
  input  logic             bit_valid,
  input  logic             step_en,
  input  logic             clr,
  input  logic             din,
  output logic [WIDTH-1:0] crc_par,
  output logic             crc_ser
);

  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] shifted;
  logic             feedback;

  assign shifted  = {rem_q[WIDTH-2:0], 1'b0};
  assign feedback = bit_valid & (din ^ rem_q[WIDTH-1]);

  always_ff @(posedge clk) begin
    if (rst_sync || clr)
      rem_q <= '0;
    else if (step_en)
      rem_q <= feedback ? (shifted ^ POLY) : shifted;
  end

  assign crc_par = rem_q;
  assign crc_ser = ~bit_valid & rem_q[WIDTH-1];

endmodule

// File: rtl/sd_serial_crc_chk.sv
module sd_serial_crc_chk #(
  parameter int WIDTH = 7
) (
  input logic             clk,
  input logic             rst_sync,
  input logic             bit_valid,
  input logic             step_en,
  input logic             clr,
  input logic             din,
  input logic [WIDTH-1:0] crc_par,
  input logic             crc_ser
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst_sync |=> (crc_par == '0 && !crc_ser));

  assert_no_feedback_R2: assert property (@(posedge clk) disable iff (rst_sync)
    (!clr && step_en && bit_valid && (din == crc_par[WIDTH-1]))
      |=> crc_par == {$past(crc_par[WIDTH-2:0]), 1'b0});

  assert_shift_out_R6: assert property (@(posedge clk) disable iff (rst_sync)
    (!clr && step_en && !bit_valid) |=> crc_par == {$past(crc_par[WIDTH-2:0]), 1'b0});

  assert_serial_msb_R6: assert property (@(posedge clk) disable iff (rst_sync)
    !bit_valid |-> crc_ser == crc_par[WIDTH-1]);

  assert_serial_quiet_R7: assert property (@(posedge clk) disable iff (rst_sync)
    bit_valid |-> !crc_ser);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst_sync)
    (!clr && !step_en) |=> $stable(crc_par));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst_sync)
    clr |=> crc_par == '0);

endmodule

bind sd_serial_crc sd_serial_crc_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_sync(rst_sync), .bit_valid(bit_valid), .step_en(step_en),
  .clr(clr), .din(din), .crc_par(crc_par), .crc_ser(crc_ser)
);

// File: tb/sd_serial_crc_tb_top.sv
module sd_serial_crc_tb_top;

  logic clk = 1'b0;
  logic rst_sync = 1'b1;
  logic bit_valid = 1'b0;
  logic step_en = 1'b0;
  logic clr = 1'b0;
  logic din = 1'b0;
  logic [6:0]  par7;
  logic [15:0] par16;
  logic ser7, ser16;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_serial_crc #(.WIDTH(7), .POLY(7'h09)) dut_i (
    .clk(clk), .rst_sync(rst_sync), .bit_valid(bit_valid), .step_en(step_en),
    .clr(clr), .din(din), .crc_par(par7), .crc_ser(ser7));

  sd_serial_crc #(.WIDTH(16), .POLY(16'h1021)) dut16_i (
    .clk(clk), .rst_sync(rst_sync), .bit_valid(bit_valid), .step_en(step_en),
    .clr(clr), .din(din), .crc_par(par16), .crc_ser(ser16));

  localparam int NV = 10;
  localparam logic [95:0] TV_DATA [NV] = '{
    96'h40_0000_0000, {40'h40_0000_0000, 7'h4A},
    96'h51_0000_0000, {40'h51_0000_0000, 7'h2A},
    96'h11_0000_0900, {40'h11_0000_0900, 7'h33},
    96'h1234567890ABCDEF, {64'h1234567890ABCDEF, 16'h2FBC},
    96'hF0F0F0F0F0F0F0F0F0F0, {80'hF0F0F0F0F0F0F0F0F0F0, 16'h63E2}};
  localparam int TV_LEN [NV] = '{40, 47, 40, 47, 40, 47, 64, 80, 80, 96};
  localparam int TV_W   [NV] = '{7, 7, 7, 7, 7, 7, 16, 16, 16, 16};
  localparam logic [15:0] TV_EXP [NV] = '{
    16'h4A, 16'h00, 16'h2A, 16'h00, 16'h33, 16'h00,
    16'h2FBC, 16'h0000, 16'h63E2, 16'h0000};
  localparam string TV_REQ [NV] = '{"R3", "R5", "R3", "R5", "R3", "R5",
                                    "R4", "R5", "R4", "R5"};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Sends bits hi..lo of data; leaves bit_valid low and settled.
  task automatic send_bits(input logic [95:0] data, input int hi, input int lo);
    bit quiet = 1'b1;
    step_en = 1'b1;
    for (int i = hi; i >= lo; i--) begin
      din = data[i];
      bit_valid = 1'b1;
      #1;
      if (ser7 || ser16) quiet = 1'b0;
      @(negedge clk);
    end
    chk("R7", {15'd0, ~quiet}, 16'd0);
    bit_valid = 1'b0;
    din = 1'b0;
    #1;
  endtask

  task automatic drain(input int w, input logic [15:0] exp);
    step_en = 1'b1;
    bit_valid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      #1;
      if (k < w) chk("R6", {15'd0, (w == 7) ? ser7 : ser16}, {15'd0, exp[w-1-k]});
      @(negedge clk);
    end
    #1;
    chk("R6", (w == 7) ? {9'd0, par7} : par16, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [6:0] held;
    repeat (3) @(negedge clk);
    chk("R1", {9'd0, par7}, 16'd0);
    chk("R1", par16, 16'd0);
    chk("R1", {15'd0, ser7 | ser16}, 16'd0);
    rst_sync = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      send_bits(TV_DATA[v], TV_LEN[v] - 1, 0);
      chk(TV_REQ[v], (TV_W[v] == 7) ? {9'd0, par7} : par16, TV_EXP[v]);
      drain(TV_W[v], TV_EXP[v]);
    end

    // R4: 512 bytes of 0xFF, then the same message followed by its remainder (R5)
    send_bits({96{1'b1}}, 4095 % 96, 0);
    for (int b = 0; b < 4096 - (4095 % 96) - 1; b += 96)
      send_bits({96{1'b1}}, 95, 0);
    chk("R4", par16, 16'h7FA1);
    step_en = 1'b0;
    @(negedge clk);
    send_bits(96'h7FA1, 15, 0);
    chk("R5", par16, 16'h0000);
    drain(16, 16'h0000);

    // R8: strobe low holds in absorb mode and in shift-out mode
    send_bits(96'h40_0000_0000, 39, 20);
    held = par7;
    step_en = 1'b0;
    bit_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      din = i[0];
      @(negedge clk);
    end
    chk("R8", {9'd0, par7}, {9'd0, held});
    send_bits(96'h40_0000_0000, 19, 0);
    chk("R2", {9'd0, par7}, 16'h4A);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", {9'd0, par7}, 16'h4A);
    chk("R8", {15'd0, ser7}, 16'd1);
    drain(7, 16'h4A);

    // R9: clear with qualifier high, strobe low and high, and during shift-out
    send_bits(96'h51_0000_0000, 39, 30);
    clr = 1'b1; bit_valid = 1'b1; step_en = 1'b0; din = 1'b1;
    @(negedge clk);
    chk("R9", {9'd0, par7}, 16'd0);
    chk("R9", par16, 16'd0);
    send_bits(96'h51_0000_0000, 39, 30);
    clr = 1'b1; bit_valid = 1'b1; step_en = 1'b1; din = 1'b1;
    @(negedge clk);
    chk("R9", {9'd0, par7}, 16'd0);
    clr = 1'b0;
    send_bits(96'h51_0000_0000, 39, 0);
    chk("R9", {9'd0, par7}, 16'h2A);
    drain(7, 16'h2A);
    send_bits(96'h11_0000_0900, 39, 0);
    clr = 1'b1;
    @(negedge clk);
    #1;
    chk("R9", {9'd0, par7}, 16'd0);
    chk("R9", {15'd0, ser7 | ser16}, 16'd0);
    clr = 1'b0;

    // R1: reset in the middle of a message
    send_bits(96'h1234567890ABCDEF, 63, 30);
    rst_sync = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", par16, 16'd0);
    chk("R1", {15'd0, ser16}, 16'd0);
    rst_sync = 1'b0;
    @(negedge clk);
    send_bits(96'h1234567890ABCDEF, 63, 0);
    chk("R2", par16, 16'h2FBC);
    drain(16, 16'h2FBC);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule